// File: doc/BRIEF.md
# Program Counter Next-Address Sequencer

This block owns the program counter of a small 8-bit controller core and picks its value for the next instruction cycle. Every clock edge is one instruction cycle. The decode logic around the block raises one or more request inputs. The block then chooses a single action by fixed priority: reset, an accepted interrupt, a return, a jump or call, a write of the low counter byte, a skip, or a plain increment.

The counter width (11, 12 or 13 bits) is a parameter. All arithmetic wraps modulo two to the power of that width. Interrupt sources have fixed vector addresses. The layout of those addresses depends on whether the core has a second timer, which is also a parameter. Calls and accepted interrupts save the following address on an internal circular return stack. A return takes the saved address back off the stack. If a push arrives when the stack is already full, the oldest entry is lost and a sticky overflow flag is set.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x000 and `stk_ovf` is 0, and the return stack becomes empty.
- R2: In a cycle with no other action, `pc` advances by 1, and the all-ones address wraps to 0x000.
- R3: An accepted interrupt loads a fixed vector. Source code 0 (external) gives 0x004 and code 1 (timer 0) gives 0x008. With `HAS_TIMER1`=1: code 2 (timer 1) gives 0x00C, code 3 (A/D) gives 0x010 and code 4 (serial bus) gives 0x014. With `HAS_TIMER1`=0: code 3 gives 0x00C and code 4 gives 0x010.
- R4: A skip request advances `pc` by 2, modulo 2^PC_W.
- R5: A low-byte write sets `pc[7:0]` to `pcl_data` and leaves `pc[PC_W-1:8]` unchanged.
- R6: A jump or a call loads every `pc` bit from `target`.
- R7: A call and an accepted interrupt each push `pc`+1 onto the return stack. A return loads `pc` with the most recently pushed entry and removes that entry (last in, first out).
- R8: A return while the stack is empty has no effect. The next lower-priority action is taken instead, and the stack stays empty.
- R9: A push onto a stack that already holds `STACK_DEPTH` entries drops the oldest entry and sets `stk_ovf`. The flag stays set until reset. The `STACK_DEPTH` newest entries can still be returned to.
- R10: If several requests arrive in the same cycle, they are served in this order: interrupt, return, jump/call, low-byte write, skip, increment.
- R11: An interrupt source code that has no vector is ignored. This covers codes 5 to 7, and also code 2 when `HAS_TIMER1`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_ack | input | 1 | Interrupt accepted this cycle |
| irq_src | input | 3 | Source code of the accepted interrupt |
| skip | input | 1 | Skip the next instruction (advance by 2) |
| pcl_wr | input | 1 | Write of the low counter byte |
| pcl_data | input | 8 | Value written into the low byte |
| jump | input | 1 | Jump to `target` |
| call | input | 1 | Call `target` and save the return address |
| target | input | PC_W | Address field of the instruction word |
| ret | input | 1 | Return from subroutine |
| pc | output | PC_W | Current program counter |
| stk_ovf | output | 1 | Sticky return-stack overflow flag |

## Verification
The hardest state to reach from the ports is a stack that has wrapped: the oldest entry has been overwritten, and the newest entries must still come back in order. The stimulus issues one more call than the stack depth, each to a distinct target, so that every saved address can be told apart. It then returns once per entry, and then once more so that the empty-stack return is exercised. Priority is covered with cycles that raise several requests together while the stack holds entries, so that a return really competes with the requests below it. A second instance built without the second timer receives the same interrupt cycles to check the other vector layout.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // Interrupt source codes seen on irq_src
    typedef enum logic [2:0] {
        SRC_EXT  = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_TMR1 = 3'd2,
        SRC_ADC  = 3'd3,
        SRC_SBUS = 3'd4
    } irq_src_e;

    // Action chosen for the coming cycle
    typedef enum logic [2:0] {
        ACT_INC  = 3'd0,
        ACT_SKIP = 3'd1,
        ACT_PCL  = 3'd2,
        ACT_LOAD = 3'd3,
        ACT_RET  = 3'd4,
        ACT_IRQ  = 3'd5
    } act_e;

    localparam int LOW_BYTE_W = 8;
    localparam int SLOT_SHIFT = 2;  // vectors lie 4 words apart
    localparam int SLOT_W     = 3;

endpackage

// File: rtl/pcs_vector.sv
module pcs_vector
    import pcs_pkg::*;
#(
    parameter int PC_W       = 11,
    parameter bit HAS_TIMER1 = 1'b1
) (
    input  logic [2:0]      src,
    output logic            hit,
    output logic [PC_W-1:0] vec
);

    logic [SLOT_W-1:0] slot;

    generate
        if (HAS_TIMER1) begin : g_two_timers
            always_comb begin
                hit  = 1'b1;
                slot = '0;
                case (irq_src_e'(src))
                    SRC_EXT:  slot = 3'd1;
                    SRC_TMR0: slot = 3'd2;
                    SRC_TMR1: slot = 3'd3;
                    SRC_ADC:  slot = 3'd4;
                    SRC_SBUS: slot = 3'd5;
                    default:  hit  = 1'b0;
                endcase
            end
        end else begin : g_one_timer
            always_comb begin
                hit  = 1'b1;
                slot = '0;
                case (irq_src_e'(src))
                    SRC_EXT:  slot = 3'd1;
                    SRC_TMR0: slot = 3'd2;
                    SRC_ADC:  slot = 3'd3;
                    SRC_SBUS: slot = 3'd4;
                    default:  hit  = 1'b0;
                endcase
            end
        end
    endgenerate

    assign vec = PC_W'({slot, {SLOT_SHIFT{1'b0}}});

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         empty,
    output logic         ovf
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [PW-1:0] rp;
    logic [PW-1:0] wp_inc;

    assign rp       = (stk_q.wp == '0) ? LAST : stk_q.wp - PW'(1);
    assign wp_inc   = (stk_q.wp == LAST) ? '0 : stk_q.wp + PW'(1);
    assign top_data = stk_q.mem[rp];
    assign empty    = (stk_q.cnt == '0);
    assign ovf      = stk_q.ovf;

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d.mem[stk_q.wp] = push_data;
            stk_d.wp            = wp_inc;
            if (stk_q.cnt == FULL) begin
                stk_d.ovf = 1'b1;
            end else begin
                stk_d.cnt = stk_q.cnt + CW'(1);
            end
        end else if (pop && !empty) begin
            stk_d.wp  = rp;
            stk_d.cnt = stk_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

endmodule

// File: rtl/pcs_next.sv
module pcs_next
    import pcs_pkg::*;
#(
    parameter int PC_W = 11
) (
    input  logic [PC_W-1:0]       pc_q,
    input  logic                  irq_take,
    input  logic [PC_W-1:0]       irq_vec,
    input  logic                  ret_req,
    input  logic                  stk_empty,
    input  logic [PC_W-1:0]       stk_top,
    input  logic                  jump,
    input  logic                  call,
    input  logic [PC_W-1:0]       target,
    input  logic                  pcl_wr,
    input  logic [LOW_BYTE_W-1:0] pcl_data,
    input  logic                  skip,
    output logic [PC_W-1:0]       pc_n,
    output logic [PC_W-1:0]       ret_addr,
    output logic                  push,
    output logic                  pop
);

    act_e act;

    assign ret_addr = pc_q + PC_W'(1);

    always_comb begin
        if (irq_take)                    act = ACT_IRQ;
        else if (ret_req && !stk_empty)  act = ACT_RET;
        else if (jump || call)           act = ACT_LOAD;
        else if (pcl_wr)                 act = ACT_PCL;
        else if (skip)                   act = ACT_SKIP;
        else                             act = ACT_INC;
    end

    always_comb begin
        push = 1'b0;
        pop  = 1'b0;
        case (act)
            ACT_IRQ: begin
                pc_n = irq_vec;
                push = 1'b1;
            end
            ACT_RET: begin
                pc_n = stk_top;
                pop  = 1'b1;
            end
            ACT_LOAD: begin
                pc_n = target;
                push = call;
            end
            ACT_PCL:  pc_n = {pc_q[PC_W-1:LOW_BYTE_W], pcl_data};
            ACT_SKIP: pc_n = pc_q + PC_W'(2);
            default:  pc_n = ret_addr;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int PC_W        = 11,
    parameter int STACK_DEPTH = 8,
    parameter bit HAS_TIMER1  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_ack,
    input  logic [2:0]            irq_src,
    input  logic                  skip,
    input  logic                  pcl_wr,
    input  logic [LOW_BYTE_W-1:0] pcl_data,
    input  logic                  jump,
    input  logic                  call,
    input  logic [PC_W-1:0]       target,
    input  logic                  ret,
    output logic [PC_W-1:0]       pc,
    output logic                  stk_ovf
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            vec_hit;
    logic [PC_W-1:0] vec_addr;
    logic            irq_take;
    logic [PC_W-1:0] pc_n;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] stk_top;
    logic            stk_empty;
    logic            do_push;
    logic            do_pop;

    pcs_vector #(
        .PC_W       (PC_W),
        .HAS_TIMER1 (HAS_TIMER1)
    ) vec_i (
        .src (irq_src),
        .hit (vec_hit),
        .vec (vec_addr)
    );

    assign irq_take = irq_ack && vec_hit;

    pcs_next #(
        .PC_W (PC_W)
    ) next_i (
        .pc_q      (seq_q.pc),
        .irq_take  (irq_take),
        .irq_vec   (vec_addr),
        .ret_req   (ret),
        .stk_empty (stk_empty),
        .stk_top   (stk_top),
        .jump      (jump),
        .call      (call),
        .target    (target),
        .pcl_wr    (pcl_wr),
        .pcl_data  (pcl_data),
        .skip      (skip),
        .pc_n      (pc_n),
        .ret_addr  (ret_addr),
        .push      (do_push),
        .pop       (do_pop)
    );

    pcs_stack #(
        .W     (PC_W),
        .DEPTH (STACK_DEPTH)
    ) stack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (ret_addr),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .ovf       (stk_ovf)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.pc = pc_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc = seq_q.pc;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int PC_W       = 11,
    parameter bit HAS_TIMER1 = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_ack,
    input logic [2:0]      irq_src,
    input logic            skip,
    input logic            pcl_wr,
    input logic [7:0]      pcl_data,
    input logic            jump,
    input logic            call,
    input logic [PC_W-1:0] target,
    input logic            ret,
    input logic [PC_W-1:0] pc,
    input logic            stk_ovf
);

    logic no_irq;
    logic above_pcl;
    logic idle;

    assign no_irq    = !irq_ack;
    assign above_pcl = irq_ack || ret || jump || call;
    assign idle      = !above_pcl && !pcl_wr && !skip;

    initial begin
        assert_width_range_R6: assert (PC_W >= 11 && PC_W <= 13);
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !stk_ovf));

    assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> pc == PC_W'($past(pc) + PC_W'(1)));

    assert_vec_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_src == 3'd0) |=> pc == PC_W'(4));

    assert_vec_tmr0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_src == 3'd1) |=> pc == PC_W'(8));

    assert_vec_adc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_src == 3'd3) |=> pc == (HAS_TIMER1 ? PC_W'(16) : PC_W'(12)));

    assert_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && !above_pcl && !pcl_wr) |=> pc == PC_W'($past(pc) + PC_W'(2)));

    assert_pcl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pcl_wr && !above_pcl) |=>
            (pc[7:0] == $past(pcl_data) && pc[PC_W-1:8] == $past(pc[PC_W-1:8])));

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((jump || call) && no_irq && !ret) |=> pc == $past(target));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> stk_ovf);

    assert_bad_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_src >= 3'd5 && !ret && !jump && !call && !pcl_wr && !skip)
            |=> pc == PC_W'($past(pc) + PC_W'(1)));

endmodule

bind pc_sequencer pcs_checker #(
    .PC_W       (PC_W),
    .HAS_TIMER1 (HAS_TIMER1)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_ack  (irq_ack),
    .irq_src  (irq_src),
    .skip     (skip),
    .pcl_wr   (pcl_wr),
    .pcl_data (pcl_data),
    .jump     (jump),
    .call     (call),
    .target   (target),
    .ret      (ret),
    .pc       (pc),
    .stk_ovf  (stk_ovf)
);

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;

    localparam int PC_W  = 11;
    localparam int DEPTH = 8;
    localparam int MASK  = (1 << PC_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_ack = 1'b0;
    logic [2:0]      irq_src = '0;
    logic            skip = 1'b0;
    logic            pcl_wr = 1'b0;
    logic [7:0]      pcl_data = '0;
    logic            jump = 1'b0;
    logic            call = 1'b0;
    logic [PC_W-1:0] target = '0;
    logic            ret = 1'b0;
    logic [PC_W-1:0] pc, pc_nt;
    logic            stk_ovf, stk_ovf_nt;

    always #2 clk = ~clk;  // 250 MHz

    pc_sequencer #(.PC_W(PC_W), .STACK_DEPTH(DEPTH), .HAS_TIMER1(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_src(irq_src),
        .skip(skip), .pcl_wr(pcl_wr), .pcl_data(pcl_data), .jump(jump),
        .call(call), .target(target), .ret(ret), .pc(pc), .stk_ovf(stk_ovf)
    );

    pc_sequencer #(.PC_W(PC_W), .STACK_DEPTH(DEPTH), .HAS_TIMER1(1'b0)) dut_nt (
        .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_src(irq_src),
        .skip(skip), .pcl_wr(pcl_wr), .pcl_data(pcl_data), .jump(jump),
        .call(call), .target(target), .ret(ret), .pc(pc_nt), .stk_ovf(stk_ovf_nt)
    );

    typedef struct {
        int    pc;
        bit    ovf;
        int    nt;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;

    // Reference state built from the requirements
    int m_pc = 0;
    int m_stk[$];
    bit m_ovf = 1'b0;

    function automatic int vec_of(int src);
        case (src)
            0: return 4;
            1: return 8;
            2: return 12;
            3: return 16;
            4: return 20;
            default: return -1;
        endcase
    endfunction

    function automatic void m_push(int v);
        if (m_stk.size() == DEPTH) begin
            void'(m_stk.pop_front());
            m_ovf = 1'b1;
        end
        m_stk.push_back(v & MASK);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of requests and queue the expected result
    task automatic step(bit ia, int src, bit sk, bit pw, int pd, bit jp, bit cl,
                        int tg, bit rt, string tag, int nt_exp = -1);
        exp_t e;
        int   v;
        irq_ack = ia; irq_src = src[2:0]; skip = sk; pcl_wr = pw;
        pcl_data = pd[7:0]; jump = jp; call = cl; target = tg[PC_W-1:0]; ret = rt;
        v = vec_of(src);
        if (ia && v >= 0) begin
            m_push(m_pc + 1);
            m_pc = v;
        end else if (rt && m_stk.size() > 0) begin
            m_pc = m_stk.pop_back();
        end else if (jp || cl) begin
            if (cl) m_push(m_pc + 1);
            m_pc = tg & MASK;
        end else if (pw) begin
            m_pc = (m_pc & ~32'hFF) | (pd & 32'hFF);
        end else if (sk) begin
            m_pc = (m_pc + 2) & MASK;
        end else begin
            m_pc = (m_pc + 1) & MASK;
        end
        e.pc = m_pc; e.ovf = m_ovf; e.nt = nt_exp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic jmp(int tg, string tag);
        step(0, 0, 0, 0, 0, 1, 0, tg, 0, tag);
    endtask
    task automatic cll(int tg, string tag);
        step(0, 0, 0, 0, 0, 0, 1, tg, 0, tag);
    endtask
    task automatic rtn(string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
    endtask
    task automatic irq(int src, string tag, int nt_exp);
        step(1, src, 0, 0, 0, 0, 0, 0, 0, tag, nt_exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_ack = 0; skip = 0; pcl_wr = 0; jump = 0; call = 0; ret = 0;
        m_pc = 0; m_ovf = 0; m_stk.delete();
        @(negedge clk);
        @(negedge clk);
        check("R1 pc in reset", int'(pc), 0);
        check("R1 ovf in reset", int'(stk_ovf), 0);
        rst_n = 1'b1;
    endtask

    // Monitor: compare each queued item after the edge that produces it
    always begin
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " pc"}, int'(pc), e.pc);
            check({e.tag, " ovf"}, int'(stk_ovf), int'(e.ovf));
            if (e.nt >= 0) check({e.tag, " pc (no timer1)"}, int'(pc_nt), e.nt);
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        idle("R2 inc a");
        idle("R2 inc b");
        idle("R2 inc c");
        jmp(12'h7FF, "R6 jump to top");
        idle("R2 wrap");
        jmp(12'h7FE, "R6 jump");
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 skip wraps");
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 skip");
        jmp(12'h2A5, "R6 jump");
        step(0, 0, 0, 1, 8'h3C, 0, 0, 0, 0, "R5 low byte write");
        step(0, 0, 0, 1, 8'hFF, 0, 0, 0, 0, "R5 low byte write ff");

        // Vector layout, both variants
        do_reset();
        irq(0, "R3 ext vector", 4);
        irq(1, "R3 timer0 vector", 8);
        jmp(12'h100, "R6 jump");
        irq(2, "R3 timer1 vector / R11 absent source", 12'h101);
        jmp(12'h200, "R6 jump");
        irq(3, "R3 adc vector", 12'h00C);
        jmp(12'h300, "R6 jump");
        irq(4, "R3 serial vector", 12'h010);
        jmp(12'h400, "R6 jump");
        irq(5, "R11 code 5 ignored", 12'h401);
        irq(7, "R11 code 7 ignored", 12'h402);

        // Calls and returns
        do_reset();
        rtn("R8 return on empty stack");
        step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R8 empty return falls to skip");
        jmp(12'h050, "R6 jump");
        cll(12'h300, "R6 call");
        cll(12'h400, "R6 nested call");
        irq(1, "R7 irq pushes", -1);
        rtn("R7 return from irq");
        rtn("R7 return inner");
        rtn("R7 return outer");
        rtn("R8 empty again");

        // Priority
        cll(12'h123, "R6 call for priority");
        step(1, 0, 1, 1, 8'h55, 1, 1, 12'h700, 1, "R10 irq beats all");
        step(0, 0, 1, 1, 8'h55, 0, 1, 12'h700, 1, "R10 return beats call");
        step(0, 0, 1, 1, 8'h55, 1, 0, 12'h700, 0, "R10 jump beats pcl");
        step(0, 0, 1, 1, 8'h66, 0, 0, 0, 0, "R10 pcl beats skip");
        step(1, 6, 1, 0, 0, 0, 0, 0, 0, "R10 R11 bad source then skip");

        // Overflow and wrap of the stack
        do_reset();
        for (int i = 0; i <= DEPTH; i++) cll(12'h100 + 16 * i, "R9 fill stack");
        for (int i = 0; i < DEPTH; i++) rtn("R9 return after overflow");
        rtn("R9 R8 return past depth");
        idle("R9 flag sticky");
        do_reset();
        idle("R1 after reset");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule